// File: doc/BRIEF.md
# Predicated Commit Gate

This block sits at the commit point of a pipeline in which nearly every instruction carries a 4-bit condition. For each instruction slot it checks that condition against the architectural N, Z, C and V flags. The instruction commits only when the condition holds. When it does not, the block squashes the instruction: the register write and the flag write both stay low, and fetch is not redirected.

The block owns the flag register. A compare instruction subtracts its second operand from its first. If the compare commits, the flags are loaded from that result at the next clock edge, so any later predicated instruction sees them. A compare never writes a destination register. The reset input is asynchronous and active-low, and the block releases it internally in step with the clock.

Top module: `pie_gate`

## Requirements
- R1: After reset, `flags_o` is 0 and no write enable is asserted. `flags_o` holds N in bit 3, Z in bit 2, C in bit 1 and V in bit 0.
- R2: Condition code 0xE always passes. Condition code 0xF never passes.
- R3: Code 0x0 passes when Z=1. Code 0x1 passes when Z=0.
- R4: Code 0x2 passes when C=1 and code 0x3 when C=0. Code 0x4 passes when N=1 and code 0x5 when N=0. Code 0x6 passes when V=1 and code 0x7 when V=0.
- R5: Code 0xA passes when N==V and code 0xB when N!=V, so exactly one of each such pair passes. Code 0xC passes when Z=0 and N==V. Code 0xD passes when Z=1 or N!=V.
- R6: Code 0x8 passes when C=1 and Z=0. Code 0x9 passes when C=0 or Z=1.
- R7: `exec_o` equals `valid_i` AND the condition result. A squashed slot asserts neither `rd_we_o` nor `flag_we_o`. A committed non-compare slot drives `rd_we_o` equal to `rd_we_req_i`.
- R8: A committed compare computes a-b. One clock later the flags read as follows: N is the sign bit of the result, Z is set when the result is zero, C is set when there is no borrow (a >= b unsigned), and V is set on signed overflow.
- R9: A compare never asserts `rd_we_o`. A committed compare asserts `flag_we_o`.
- R10: When `valid_i` is low, nothing commits and the flags stay unchanged.
- R11: A squashed compare leaves the flags unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| valid_i | input | 1 | An instruction occupies the slot this cycle |
| cond_i | input | 4 | Condition field of the instruction |
| is_cmp_i | input | 1 | The instruction is a compare |
| rd_we_req_i | input | 1 | The instruction wants to write its destination register |
| op_a_i | input | W | First compare operand |
| op_b_i | input | W | Second compare operand (subtracted) |
| exec_o | output | 1 | The slot commits |
| rd_we_o | output | 1 | Gated register write enable |
| flag_we_o | output | 1 | Gated flag update enable |
| flags_o | output | 4 | Current flags {N,Z,C,V} |

## Verification
With a 4-bit operand width, the bench runs a compare for every operand pair. Across these pairs the flags reach every combination a subtraction can produce, including unsigned borrow without signed overflow and signed overflow in both directions. After each compare it sweeps all sixteen condition codes, so each code is tested against each reachable flag state. This separates the signed-order codes from the unsigned ones, and each code from its complement. Separate stimulus covers a squashed compare, an empty slot and a write request that is dropped, which separates gating by the condition from gating by the slot's valid bit.

// File: rtl/pie_pkg.sv
package pie_pkg;

  typedef enum logic [3:0] {
    CND_EQ = 4'h0, CND_NE = 4'h1, CND_CS = 4'h2, CND_CC = 4'h3,
    CND_MI = 4'h4, CND_PL = 4'h5, CND_VS = 4'h6, CND_VC = 4'h7,
    CND_HI = 4'h8, CND_LS = 4'h9, CND_GE = 4'hA, CND_LT = 4'hB,
    CND_GT = 4'hC, CND_LE = 4'hD, CND_AL = 4'hE, CND_NV = 4'hF
  } cond_e;

  typedef struct packed {
    logic n;
    logic z;
    logic c;
    logic v;
  } flags_t;

endpackage

// File: rtl/pie_rst_sync.sv
module pie_rst_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  output logic rst_sync_n
);
  logic [STAGES-1:0] chain_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) chain_q <= '0;
    else        chain_q <= {chain_q[STAGES-2:0], 1'b1};
  end

  assign rst_sync_n = chain_q[STAGES-1];
endmodule

// File: rtl/pie_cond_eval.sv
module pie_cond_eval
  import pie_pkg::*;
(
  input  logic [3:0] cond_i,
  input  flags_t     flags_i,
  output logic       pass_o
);
  logic sgn_ge;

  always_comb begin
    sgn_ge = (flags_i.n == flags_i.v);
    unique case (cond_e'(cond_i))
      CND_EQ:  pass_o = flags_i.z;
      CND_NE:  pass_o = !flags_i.z;
      CND_CS:  pass_o = flags_i.c;
      CND_CC:  pass_o = !flags_i.c;
      CND_MI:  pass_o = flags_i.n;
      CND_PL:  pass_o = !flags_i.n;
      CND_VS:  pass_o = flags_i.v;
      CND_VC:  pass_o = !flags_i.v;
      CND_HI:  pass_o = flags_i.c && !flags_i.z;
      CND_LS:  pass_o = !flags_i.c || flags_i.z;
      CND_GE:  pass_o = sgn_ge;
      CND_LT:  pass_o = !sgn_ge;
      CND_GT:  pass_o = !flags_i.z && sgn_ge;
      CND_LE:  pass_o = flags_i.z || !sgn_ge;
      CND_AL:  pass_o = 1'b1;
      default: pass_o = 1'b0;
    endcase
  end
endmodule

// File: rtl/pie_cmp_flags.sv
module pie_cmp_flags
  import pie_pkg::*;
#(
  parameter int W = 32
) (
  input  logic [W-1:0] a_i,
  input  logic [W-1:0] b_i,
  output flags_t       flags_o
);
  localparam int MSB = W - 1;

  logic [W:0]   wide_diff;
  logic [W-1:0] diff;

  always_comb begin
    wide_diff = {1'b0, a_i} - {1'b0, b_i};
    diff      = wide_diff[W-1:0];
    flags_o.n = diff[MSB];
    flags_o.z = (diff == '0);
    flags_o.c = !wide_diff[W];
    flags_o.v = (a_i[MSB] != b_i[MSB]) && (diff[MSB] != a_i[MSB]);
  end
endmodule

// File: rtl/pie_flag_reg.sv
module pie_flag_reg
  import pie_pkg::*;
(
  input  logic   clk,
  input  logic   rst_n,
  input  logic   load_en,
  input  flags_t load_val,
  output flags_t flags_q
);
  flags_t flags_d;

  always_comb begin
    flags_d = flags_q;
    if (load_en) flags_d = load_val;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) flags_q <= '0;
    else        flags_q <= flags_d;
  end
endmodule

// File: rtl/pie_gate.sv
module pie_gate
  import pie_pkg::*;
#(
  parameter int W = 32
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         valid_i,
  input  logic [3:0]   cond_i,
  input  logic         is_cmp_i,
  input  logic         rd_we_req_i,
  input  logic [W-1:0] op_a_i,
  input  logic [W-1:0] op_b_i,
  output logic         exec_o,
  output logic         rd_we_o,
  output logic         flag_we_o,
  output logic [3:0]   flags_o
);
  logic   rst_int_n;
  logic   cond_pass;
  flags_t cur_flags;
  flags_t cmp_result;

  pie_rst_sync #(.STAGES(2)) u_rst (
    .clk        (clk),
    .rst_n      (rst_n),
    .rst_sync_n (rst_int_n)
  );

  pie_cond_eval u_eval (
    .cond_i  (cond_i),
    .flags_i (cur_flags),
    .pass_o  (cond_pass)
  );

  pie_cmp_flags #(.W(W)) u_cmp (
    .a_i     (op_a_i),
    .b_i     (op_b_i),
    .flags_o (cmp_result)
  );

  always_comb begin
    exec_o    = valid_i && cond_pass && rst_int_n;
    rd_we_o   = exec_o && rd_we_req_i && !is_cmp_i;
    flag_we_o = exec_o && is_cmp_i;
  end

  pie_flag_reg u_flags (
    .clk      (clk),
    .rst_n    (rst_int_n),
    .load_en  (flag_we_o),
    .load_val (cmp_result),
    .flags_q  (cur_flags)
  );

  assign flags_o = cur_flags;
endmodule

// File: rtl/pie_gate_chk.sv
module pie_gate_chk #(
  parameter int W = 32
) (
  input logic         clk,
  input logic         rst_n,
  input logic         valid_i,
  input logic [3:0]   cond_i,
  input logic         is_cmp_i,
  input logic [W-1:0] op_a_i,
  input logic [W-1:0] op_b_i,
  input logic         exec_o,
  input logic         rd_we_o,
  input logic         flag_we_o,
  input logic [3:0]   flags_o
);
  // R7
  squash_no_write_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !exec_o |-> (!rd_we_o && !flag_we_o));

  // R11
  flags_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !flag_we_o |=> $stable(flags_o));

  // R9
  cmp_no_rd_chk: assert property (@(posedge clk) disable iff (!rst_n)
    is_cmp_i |-> !rd_we_o);

  // R10
  idle_no_exec_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !valid_i |-> !exec_o);

  // R3
  eq_follows_z_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (valid_i && cond_i == 4'h0 && exec_o) |-> flags_o[2]);

  // R5
  ge_signed_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (valid_i && cond_i == 4'hA && exec_o) |-> (flags_o[3] == flags_o[0]));

  // R2
  never_code_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (cond_i == 4'hF) |-> !exec_o);

  // R8
  cmp_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
    flag_we_o |=> (flags_o[2] == ($past(op_a_i) == $past(op_b_i))));
endmodule

bind pie_gate pie_gate_chk #(.W(W)) u_chk (
  .clk       (clk),
  .rst_n     (rst_n),
  .valid_i   (valid_i),
  .cond_i    (cond_i),
  .is_cmp_i  (is_cmp_i),
  .op_a_i    (op_a_i),
  .op_b_i    (op_b_i),
  .exec_o    (exec_o),
  .rd_we_o   (rd_we_o),
  .flag_we_o (flag_we_o),
  .flags_o   (flags_o)
);

// File: tb/sim_pie_gate.sv
module sim_pie_gate;
  localparam int W = 4;
  localparam int HALF = 2;

  logic         clk;
  logic         rst_n;
  logic         valid_i;
  logic [3:0]   cond_i;
  logic         is_cmp_i;
  logic         rd_we_req_i;
  logic [W-1:0] op_a_i;
  logic [W-1:0] op_b_i;
  logic         exec_o;
  logic         rd_we_o;
  logic         flag_we_o;
  logic [3:0]   flags_o;

  int compared;
  int mismatched;
  bit finished;

  pie_gate #(.W(W)) u0 (
    .clk(clk), .rst_n(rst_n), .valid_i(valid_i), .cond_i(cond_i),
    .is_cmp_i(is_cmp_i), .rd_we_req_i(rd_we_req_i), .op_a_i(op_a_i),
    .op_b_i(op_b_i), .exec_o(exec_o), .rd_we_o(rd_we_o),
    .flag_we_o(flag_we_o), .flags_o(flags_o)
  );

  initial clk = 1'b0;
  always #HALF clk = ~clk;

  task automatic check(input string req, input int act, input int exp);
    compared++;
    if (act != exp) begin
      mismatched++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  function automatic logic [3:0] exp_flags(input int a, input int b);
    int d, sa, sb, sd;
    logic n, z, c, v;
    d  = (a - b) & 15;
    sa = (a > 7) ? a - 16 : a;
    sb = (b > 7) ? b - 16 : b;
    sd = sa - sb;
    n = (d >= 8);
    z = (d == 0);
    c = (a >= b);
    v = (sd > 7) || (sd < -8);
    return {n, z, c, v};
  endfunction

  function automatic logic exp_pass(input int code, input logic [3:0] f);
    logic n, z, c, v;
    {n, z, c, v} = f;
    case (code)
      0: return z;          1: return !z;
      2: return c;          3: return !c;
      4: return n;          5: return !n;
      6: return v;          7: return !v;
      8: return c && !z;    9: return !c || z;
      10: return n == v;    11: return n != v;
      12: return !z && n == v;
      13: return z || n != v;
      14: return 1'b1;
      default: return 1'b0;
    endcase
  endfunction

  function automatic string tag_of(input int code);
    if (code >= 14) return "R2";
    if (code <= 1) return "R3";
    if (code <= 7) return "R4";
    if (code <= 9) return "R6";
    return "R5";
  endfunction

  task automatic do_cmp(input int a, input int b, input int code, input logic v);
    @(negedge clk);
    valid_i = v; is_cmp_i = 1'b1; rd_we_req_i = 1'b1; cond_i = 4'(code);
    op_a_i = W'(a); op_b_i = W'(b);
    #1;
    check("R9", rd_we_o, 0);
  endtask

  initial begin
    logic [3:0] ef;
    logic [3:0] held;
    int ge_hits, lt_hits;
    compared = 0; mismatched = 0; finished = 0;
    rst_n = 1'b0; valid_i = 0; cond_i = 0; is_cmp_i = 0; rd_we_req_i = 0;
    op_a_i = '0; op_b_i = '0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    repeat (3) @(negedge clk);
    check("R1", flags_o, 0);
    check("R1", rd_we_o, 0);
    check("R1", flag_we_o, 0);

    for (int a = 0; a < 16; a++) begin
      for (int b = 0; b < 16; b++) begin
        do_cmp(a, b, 14, 1'b1);
        check("R9", flag_we_o, 1);
        ef = exp_flags(a, b);
        @(negedge clk);
        is_cmp_i = 1'b0; valid_i = 1'b0;
        #1;
        check("R8", flags_o, ef);
        ge_hits = 0; lt_hits = 0;
        for (int c = 0; c < 16; c++) begin
          @(negedge clk);
          valid_i = 1'b1; rd_we_req_i = 1'b1; cond_i = 4'(c);
          #1;
          check(tag_of(c), exec_o, exp_pass(c, ef));
          check("R7", rd_we_o, exp_pass(c, ef));
          check("R9", flag_we_o, 0);
          if (c == 10) ge_hits = exec_o;
          if (c == 11) lt_hits = exec_o;
        end
        check("R5", ge_hits + lt_hits, 1);
        check("R8", flags_o, ef);
      end
    end

    // committed non-compare without write request
    @(negedge clk);
    valid_i = 1; is_cmp_i = 0; rd_we_req_i = 0; cond_i = 4'hE; #1;
    check("R7", exec_o, 1);
    check("R7", rd_we_o, 0);

    // squashed compare
    do_cmp(5, 5, 14, 1'b1);
    @(negedge clk);
    held = flags_o;
    check("R8", held, 4'b0110);
    do_cmp(0, 1, 1, 1'b1);
    check("R7", exec_o, 0);
    check("R11", flag_we_o, 0);
    @(negedge clk);
    valid_i = 0; is_cmp_i = 0; #1;
    check("R11", flags_o, held);

    // empty slot
    do_cmp(0, 1, 14, 1'b0);
    check("R10", exec_o, 0);
    check("R10", flag_we_o, 0);
    @(negedge clk);
    #1;
    check("R10", flags_o, held);

    finished = 1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
    $finish;
  end

  initial begin
    #(HALF * 2 * 200000);
    if (!finished) begin
      compared++; mismatched++;
      $display("FAIL watchdog actual=hung expected=done");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
      $finish;
    end
  end
endmodule